// File: doc/BRIEF.md
# Counted Multi-Grant Request Checker

This block watches a request/grant handshake in which every request states how many grant pulses it expects. When the request line rises, the block latches the count field that comes with it. It opens a fixed-length window for that request and counts the grant pulses credited to it. When the window closes, it emits a one-cycle pass or fail pulse. The pulse carries the slot index that held the request.

Requests may overlap. Each live grant goes to the oldest outstanding request that still lacks grants, so one grant never satisfies two requests. A grant that no request can take waits for two cycles in a short history. A request edge arriving within those two cycles may claim it as an early grant. A grant that nobody claims is reported as stray. Up to a parameterised number of requests may be in flight. A request edge that finds every slot busy is dropped and sets a sticky overflow flag.

Top module: `multi_grant_checker`

## Requirements
- R1: The required count is latched from `reqCount` only in a cycle where `req` is 1 after being 0 in the previous cycle. Holding `req` high starts no further request, and changes to `reqCount` while it stays high are ignored.
- R2: A request whose edge is sampled in cycle E counts grants sampled in cycles E+1 through E+WINDOW. Its verdict pulse is visible for exactly one cycle, after the clock edge of cycle E+WINDOW.
- R3: A request passes (`passPulse`=1) when its credited grants equal its required count, and fails (`failPulse`=1) when they are fewer. The two pulses are never high together.
- R4: Unclaimed grants sampled one or two cycles before a request edge are credited to that request, oldest first, up to its required count. Each such grant is credited at most once.
- R5: A grant sampled in the same cycle as a request edge is not credited to that new request.
- R6: A live grant is credited to the oldest outstanding request whose credited count is below its required count.
- R7: A grant that is neither credited to an outstanding request nor claimed by a request edge within the next two cycles raises `strayGnt` for one cycle, visible after the clock edge two cycles after that grant was sampled.
- R8: At most DEPTH (default 8) requests are outstanding. A request edge that finds all slots full is dropped and sets `overflowFlag`, which stays at 1 until reset.
- R9: A request with a required count of 0 takes no grant and passes when its window closes.
- R10: A synchronous reset (`rst`=1) clears all outstanding requests, the history and the flag. All outputs read 0 after the reset clock edge.
- R11: `verdictSlot` names the slot of the request being judged. After reset, slots are assigned in request order starting at 0 and wrap modulo DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request line; its rising edge starts a request |
| reqCount | input | CW (8) | Count field of the request message: grants required |
| gnt | input | 1 | Grant pulse, one per cycle it is high |
| passPulse | output | 1 | One-cycle pulse: judged request received exactly its count |
| failPulse | output | 1 | One-cycle pulse: judged request received too few grants |
| verdictSlot | output | log2(DEPTH) | Slot index of the request being judged |
| strayGnt | output | 1 | One-cycle pulse: a grant nobody claimed |
| overflowFlag | output | 1 | Sticky: a request was dropped because all slots were busy |

## Verification
The assertions check four things on every cycle. Pass and fail never fire together, and a verdict never lasts two cycles. A stray pulse always traces back to a grant sampled three clocks earlier. The overflow flag rises only after a true request edge and never falls outside reset. The bench scenarios cover what needs a known stimulus: exact window boundaries, early-grant crediting and consumption, rejection of a same-cycle grant, and oldest-first assignment between overlapping requests. They also cover zero-count requests and slot numbering across overflow.

// File: rtl/mgc_pkg.sv
package mgc_pkg;

  // Strobes from control to the slot datapath
  typedef struct packed {
    logic alloc;   // write a new request into the slot at allocSlot
    logic credit;  // add one grant to the slot at creditSlot
  } slotStrobes_t;

endpackage

// File: rtl/mgc_slots.sv
module mgc_slots
  import mgc_pkg::*;
#(
  parameter  int DEPTH  = 8,
  parameter  int CW     = 8,
  parameter  int WINDOW = 100,
  localparam int PW     = $clog2(DEPTH),
  localparam int TW     = $clog2(WINDOW + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  slotStrobes_t     st,
  input  logic [PW-1:0]    allocSlot,
  input  logic [CW-1:0]    allocNeed,
  input  logic [1:0]       allocCredit,
  input  logic [PW-1:0]    creditSlot,
  output logic [DEPTH-1:0] hungry,
  output logic [DEPTH-1:0] oneLeft,
  output logic [DEPTH-1:0] lastCycle
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [CW-1:0] need;
    logic [CW-1:0] got;
    logic [TW-1:0] timer;

    always_ff @(posedge clk) begin
      if (rst) begin
        need  <= '0;
        got   <= '0;
        timer <= '0;
      end else if (st.alloc && allocSlot == PW'(i)) begin
        need  <= allocNeed;
        got   <= CW'(allocCredit);
        timer <= TW'(WINDOW);
      end else begin
        if (st.credit && creditSlot == PW'(i)) got <= got + CW'(1);
        if (timer != '0) timer <= timer - TW'(1);
      end
    end

    assign hungry[i]    = got < need;
    assign oneLeft[i]   = (need - got) == CW'(1);
    assign lastCycle[i] = timer == TW'(1);
  end

endmodule

// File: rtl/mgc_ctrl.sv
module mgc_ctrl
  import mgc_pkg::*;
#(
  parameter  int DEPTH = 8,
  parameter  int CW    = 8,
  localparam int PW    = $clog2(DEPTH),
  localparam int CNTW  = PW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [CW-1:0]    reqCount,
  input  logic             gnt,
  input  logic [DEPTH-1:0] hungry,
  input  logic [DEPTH-1:0] oneLeft,
  input  logic [DEPTH-1:0] lastCycle,
  output slotStrobes_t     st,
  output logic [PW-1:0]    allocSlot,
  output logic [1:0]       allocCredit,
  output logic [PW-1:0]    creditSlot,
  output logic             passPulse,
  output logic             failPulse,
  output logic [PW-1:0]    verdictSlot,
  output logic             strayGnt,
  output logic             overflowFlag
);

  logic            reqPrev, reqEdge, full, alloc, retire;
  logic            found, histNew, histOld, consumeNew, consumeOld, headPass;
  logic [PW-1:0]   head, tail, tgt;
  logic [CNTW-1:0] count;
  logic [1:0]      avail, take;

  assign reqEdge = req & ~reqPrev;
  assign full    = count == CNTW'(DEPTH);
  assign alloc   = reqEdge & ~full;
  assign retire  = (count != '0) & lastCycle[head];

  // Oldest live request still short of grants, searched from head
  always_comb begin
    logic [PW-1:0] idx;
    found = 1'b0;
    tgt   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head + PW'(k);
      if (!found && CNTW'(k) < count && hungry[idx]) begin
        found = 1'b1;
        tgt   = idx;
      end
    end
  end

  // Early grants: take up to the required count, oldest entry first
  assign avail      = {1'b0, histOld} + {1'b0, histNew};
  assign take       = (reqCount >= CW'(avail)) ? avail : reqCount[1:0];
  assign consumeOld = alloc & histOld & (take != 2'd0);
  assign consumeNew = alloc & histNew & ((take == 2'd2) | ((take == 2'd1) & ~histOld));

  assign headPass = ~hungry[head] | (oneLeft[head] & gnt & found & (tgt == head));

  assign st.alloc    = alloc;
  assign st.credit   = gnt & found;
  assign allocSlot   = tail;
  assign allocCredit = take;
  assign creditSlot  = tgt;

  always_ff @(posedge clk) begin
    if (rst) begin
      reqPrev      <= 1'b0;
      head         <= '0;
      tail         <= '0;
      count        <= '0;
      histNew      <= 1'b0;
      histOld      <= 1'b0;
      passPulse    <= 1'b0;
      failPulse    <= 1'b0;
      verdictSlot  <= '0;
      strayGnt     <= 1'b0;
      overflowFlag <= 1'b0;
    end else begin
      reqPrev      <= req;
      head         <= head + PW'(retire);
      tail         <= tail + PW'(alloc);
      count        <= count + CNTW'(alloc) - CNTW'(retire);
      histNew      <= gnt & ~found;
      histOld      <= histNew & ~consumeNew;
      strayGnt     <= histOld & ~consumeOld;
      passPulse    <= retire & headPass;
      failPulse    <= retire & ~headPass;
      verdictSlot  <= head;
      overflowFlag <= overflowFlag | (reqEdge & full);
    end
  end

endmodule

// File: rtl/multi_grant_checker.sv
module multi_grant_checker
  import mgc_pkg::*;
#(
  parameter  int DEPTH  = 8,
  parameter  int CW     = 8,
  parameter  int WINDOW = 100,
  localparam int PW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [CW-1:0] reqCount,
  input  logic          gnt,
  output logic          passPulse,
  output logic          failPulse,
  output logic [PW-1:0] verdictSlot,
  output logic          strayGnt,
  output logic          overflowFlag
);

  slotStrobes_t     st;
  logic [PW-1:0]    allocSlot, creditSlot;
  logic [1:0]       allocCredit;
  logic [DEPTH-1:0] hungry, oneLeft, lastCycle;

  mgc_ctrl #(.DEPTH(DEPTH), .CW(CW)) i_ctrl (
    .clk(clk), .rst(rst), .req(req), .reqCount(reqCount), .gnt(gnt),
    .hungry(hungry), .oneLeft(oneLeft), .lastCycle(lastCycle),
    .st(st), .allocSlot(allocSlot), .allocCredit(allocCredit),
    .creditSlot(creditSlot), .passPulse(passPulse), .failPulse(failPulse),
    .verdictSlot(verdictSlot), .strayGnt(strayGnt), .overflowFlag(overflowFlag)
  );

  mgc_slots #(.DEPTH(DEPTH), .CW(CW), .WINDOW(WINDOW)) i_slots (
    .clk(clk), .rst(rst), .st(st), .allocSlot(allocSlot),
    .allocNeed(reqCount), .allocCredit(allocCredit), .creditSlot(creditSlot),
    .hungry(hungry), .oneLeft(oneLeft), .lastCycle(lastCycle)
  );

endmodule

// File: rtl/mgc_sva.sv
module mgc_sva (
  input logic clk,
  input logic rst,
  input logic req,
  input logic gnt,
  input logic passPulse,
  input logic failPulse,
  input logic strayGnt,
  input logic overflowFlag
);

  assert_exclusive_verdict_R3: assert property (@(posedge clk) disable iff (rst)
    !(passPulse && failPulse));

  assert_verdict_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    (passPulse || failPulse) |=> !(passPulse || failPulse));

  assert_stray_from_grant_R7: assert property (@(posedge clk) disable iff (rst)
    strayGnt |-> $past(gnt, 3));

  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    overflowFlag |=> overflowFlag);

  assert_overflow_on_edge_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(overflowFlag) |-> ($past(req) && !$past(req, 2)));

  assert_reset_quiet_R10: assert property (@(posedge clk)
    rst |=> !(passPulse || failPulse || strayGnt || overflowFlag));

endmodule

bind multi_grant_checker mgc_sva i_sva (.*);

// File: tb/test_multi_grant_checker.sv
module test_multi_grant_checker;
  localparam int CLK_PERIOD = 10;
  localparam int WIN   = 100;
  localparam int DEPTH = 8;
  localparam int CW    = 8;

  logic clk = 1'b0;
  logic rst = 1'b1, req = 1'b0, gnt = 1'b0;
  logic [CW-1:0] reqCount = '0;
  logic passPulse, failPulse, strayGnt, overflowFlag;
  logic [$clog2(DEPTH)-1:0] verdictSlot;

  int cyc = 0, nChecks = 0, nErrors = 0, nV = 0, nS = 0;
  int vCyc[32], vSlot[32], vPass[32], sCyc[32];

  multi_grant_checker #(.DEPTH(DEPTH), .CW(CW), .WINDOW(WIN)) i_multi_grant_checker (
    .clk(clk), .rst(rst), .req(req), .reqCount(reqCount), .gnt(gnt),
    .passPulse(passPulse), .failPulse(failPulse), .verdictSlot(verdictSlot),
    .strayGnt(strayGnt), .overflowFlag(overflowFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // One clock; outputs are recorded just after the edge
  task automatic step();
    @(posedge clk); #1;
    cyc++;
    if (passPulse || failPulse) begin
      if (nV < 32) begin
        vCyc[nV] = cyc; vPass[nV] = int'(passPulse); vSlot[nV] = int'(verdictSlot);
      end
      nV++;
    end
    if (strayGnt) begin
      if (nS < 32) sCyc[nS] = cyc;
      nS++;
    end
  endtask

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rst = 1'b1; req = 1'b0; gnt = 1'b0; reqCount = '0;
    step(); step();
    rst = 1'b0; nV = 0; nS = 0;
  endtask

  task automatic testReset();
    doReset();
    check("R10 outputs after reset", int'({passPulse, failPulse, strayGnt, overflowFlag}), 0);
    // reset in the middle of a request drops it
    req = 1'b1; reqCount = 8'd1; step(); req = 1'b0;
    for (int k = 0; k < 5; k++) step();
    doReset();
    for (int k = 0; k < WIN + 4; k++) step();
    check("R10 no verdict after mid-request reset", nV, 0);
  endtask

  // One request with optional early, same-cycle and windowed grants
  task automatic scenSingle(string tag, int need, bit pre2, bit pre1, bit atEdge,
                            int a, int b, int c, int expPass, int expStrayOff);
    int e;
    doReset();
    gnt = pre2; step();
    gnt = pre1; step();
    req = 1'b1; reqCount = CW'(need); gnt = atEdge; step();
    e = cyc; req = 1'b0; gnt = 1'b0;
    for (int k = 1; k <= WIN + 4; k++) begin
      gnt = (k == a || k == b || k == c);
      step();
    end
    gnt = 1'b0;
    check({tag, " verdict count"}, nV, 1);
    check({tag, " verdict offset"}, vCyc[0] - e, WIN);
    check({tag, " pass"}, vPass[0], expPass);
    check({tag, " slot"}, vSlot[0], 0);
    check({tag, " stray count"}, nS, (expStrayOff < 0) ? 0 : 1);
    if (expStrayOff >= 0 && nS > 0) check({tag, " stray offset"}, sCyc[0] - e, expStrayOff);
  endtask

  task automatic testHeld();
    int e;
    doReset();
    req = 1'b1; reqCount = 8'd1; step(); e = cyc;
    reqCount = 8'd9;
    for (int k = 1; k <= 4; k++) begin gnt = (k == 2); step(); end
    req = 1'b0; gnt = 1'b0;
    for (int k = 5; k <= WIN + 4; k++) step();
    check("R1 held req gives one verdict", nV, 1);
    check("R1 count latched at edge", vPass[0], 1);
    check("R1 verdict offset", vCyc[0] - e, WIN);
  endtask

  task automatic testOverlap();
    int e;
    doReset();
    req = 1'b1; reqCount = 8'd1; step(); e = cyc;
    req = 1'b0; step();
    req = 1'b1; reqCount = 8'd2; step();
    req = 1'b0; gnt = 1'b1; step(); step();
    gnt = 1'b0;
    while (cyc < e + WIN + 4) step();
    check("R6 two verdicts", nV, 2);
    check("R6 older request passes", vPass[0], 1);
    check("R6 older verdict offset", vCyc[0] - e, WIN);
    check("R11 older slot", vSlot[0], 0);
    check("R6 younger request short", vPass[1], 0);
    check("R6 younger verdict offset", vCyc[1] - e, WIN + 2);
    check("R11 younger slot", vSlot[1], 1);
    check("R6 no stray", nS, 0);
  endtask

  task automatic testOverflow();
    int passes = 0;
    doReset();
    for (int i = 0; i < 9; i++) begin
      req = 1'b1; reqCount = 8'd0; step();
      req = 1'b0; step();
      if (i == 7) check("R8 flag clear with 8 outstanding", int'(overflowFlag), 0);
    end
    check("R8 flag set by 9th request", int'(overflowFlag), 1);
    for (int k = 0; k < WIN + 2; k++) step();
    check("R8 only 8 verdicts", nV, 8);
    for (int i = 0; i < 8 && i < nV; i++) passes += vPass[i];
    check("R9 zero-count requests pass", passes, 8);
    check("R11 last slot wraps to 7", vSlot[7], 7);
    check("R8 flag sticky", int'(overflowFlag), 1);
    doReset();
    check("R10 reset clears flag", int'(overflowFlag), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++; nErrors++;
    $display("FAIL watchdog (all R): actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    testReset();
    scenSingle("R2 R3 exact count incl last cycle", 3, 0, 0, 0, 1, 50, WIN, 1, -1);
    scenSingle("R2 grant after window", 1, 0, 0, 0, WIN + 1, 0, 0, 0, WIN + 3);
    scenSingle("R3 too few grants", 2, 0, 0, 0, 7, 0, 0, 0, -1);
    scenSingle("R7 excess grant is stray", 1, 0, 0, 0, 5, 6, 0, 1, 8);
    scenSingle("R4 two early grants", 2, 1, 1, 0, 0, 0, 0, 1, -1);
    scenSingle("R4 one early grant used", 1, 1, 1, 0, 0, 0, 0, 1, 1);
    scenSingle("R5 same-cycle grant", 1, 0, 0, 1, 0, 0, 0, 0, 2);
    scenSingle("R9 zero count ignores grant", 0, 0, 0, 0, 3, 0, 0, 1, 5);
    testHeld();
    testOverlap();
    testOverflow();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule